// File: doc/BRIEF.md
# ALU Flag Unit with Direct-Page Select

This block is the status side of a small 8-bit processor datapath. Each cycle it takes an operation code, two operands, a second high-order operand used only by the 16-bit pair test, and an external carry input. It returns the operation result combinationally, and it updates an eight-bit program status word on the next clock edge when the operation is marked valid. The status word holds, from bit 7 down to bit 0: negative (N), signed overflow (V), page select (G), break (B), half carry (H), interrupt enable (I), zero (Z) and carry (C).

Besides arithmetic, shift, rotate, transfer and bit-test flag rules, the unit owns the page select flag. It forms a 9-bit direct-page address by placing G above an 8-bit offset, so that one flag moves every direct operand between the lower and the upper 256-byte page. Dedicated commands set and clear G and I, and a clear-overflow command drops V together with H. Nothing in the command set raises V by itself.

Top module: `psw_flag_unit`

## Requirements
- R1: While reset is held and after it is released, the status word reads 00h until a valid operation changes it; the bit layout is N=7, V=6, G=5, B=4, H=3, I=2, Z=1, C=0, and no operation of this unit changes B.
- R2: Add (op 1) returns a+b+carry_in modulo 256; C is the carry out of bit 7, H the carry out of bit 3, V is set when the signed sum lies outside -128..+127, N is result bit 7, Z is set for a zero result; G, B, I stay unchanged.
- R3: Subtract (op 2) returns a-b-(1-carry_in) modulo 256; C is 1 when no borrow occurs, H is 1 when no borrow is taken from bit 4, V marks a signed result outside -128..+127, and N and Z follow the result.
- R4: Shift left (op 3) and shift right (op 4) insert 0, rotate left (op 5) and rotate right (op 6) insert carry_in; the bit shifted out goes to C, N and Z follow the result, V and H stay unchanged.
- R5: Transfer (op 7) returns b and updates only N and Z from it.
- R6: Bit test (op 8) copies b bit 7 into N and b bit 6 into V, sets Z when a AND b is zero, leaves C and H unchanged and returns a.
- R7: Pair test (op 9) treats y as the high byte and a as the low byte of a 16-bit value: Z is set only when all 16 bits are zero and N takes y bit 7; other flags stay unchanged.
- R8: Set-page (op 10) sets G and clear-page (op 11) clears it; the direct-page address is always G in bit 8 above the 8-bit offset, so G=0 addresses 000h..0FFh and G=1 addresses 100h..1FFh.
- R9: Enable (op 12) sets I and disable (op 13) clears I, with no other flag changed.
- R10: Clear-overflow (op 14) clears both V and H and nothing else; V rises only after an add, subtract or bit test.
- R11: With op_valid low the status word holds its value whatever the operation code; op 0 and op 15 change no flag even when valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation applies to the status word at the next edge |
| op | input | 4 | Operation code |
| a_in | input | 8 | First operand, low byte of the pair |
| b_in | input | 8 | Second operand or memory byte |
| y_in | input | 8 | High byte of the 16-bit pair |
| carry_in | input | 1 | Carry input for add, subtract and rotate |
| dp_offset | input | 8 | Direct-page offset |
| result | output | 8 | Combinational operation result |
| psw_q | output | 8 | Registered status word |
| dp_addr | output | 9 | Direct-page address |

## Verification
A wrong flag inside this unit shows up one clock after the offending operation at psw_q, because every flag is stored directly there; the bench compares the whole byte after every operation against an arithmetic model, so a corrupted bit is seen in the very next cycle. A stuck or inverted page flag is visible at dp_addr bit 8 in the same cycle the flag changes. Adder faults appear at result combinationally, before any edge, and the sweeps over all first operands with many second operands and both carry values expose carry-chain, half-carry and overflow errors at their boundary values.

// File: rtl/flag_pkg.sv
package flag_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_ASL  = 4'd3,
      OP_LSR  = 4'd4,
      OP_ROL  = 4'd5,
      OP_ROR  = 4'd6,
      OP_MOV  = 4'd7,
      OP_BIT  = 4'd8,
      OP_TSTW = 4'd9,
      OP_SETG = 4'd10,
      OP_CLRG = 4'd11,
      OP_EI   = 4'd12,
      OP_DI   = 4'd13,
      OP_CLRV = 4'd14,
      OP_IDLE = 4'd15
   } fu_op_e;

   localparam int PSW_W = 8;
   localparam int BIT_C = 0;
   localparam int BIT_Z = 1;
   localparam int BIT_I = 2;
   localparam int BIT_H = 3;
   localparam int BIT_B = 4;
   localparam int BIT_G = 5;
   localparam int BIT_V = 6;
   localparam int BIT_N = 7;

   typedef struct packed {
      logic n;
      logic v;
      logic h;
      logic z;
      logic c;
      logic we_n;
      logic we_v;
      logic we_h;
      logic we_z;
      logic we_c;
   } flag_upd_t;
endpackage

// File: rtl/fu_ripple_add.sv
module fu_ripple_add #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] yv,
   input  logic         ci,
   output logic [W-1:0] sum,
   output logic         c_half,
   output logic         c_sign,
   output logic         c_out
);
   localparam int HB = W / 2;

   logic [W:0] cy;
   assign cy[0] = ci;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign sum[k]  = x[k] ^ yv[k] ^ cy[k];
      assign cy[k+1] = (x[k] & yv[k]) | (cy[k] & (x[k] ^ yv[k]));
   end

   assign c_half = cy[HB];
   assign c_sign = cy[W-1];
   assign c_out  = cy[W];
endmodule

// File: rtl/fu_arith_core.sv
module fu_arith_core
   import flag_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] res,
   output flag_upd_t    upd
);
   fu_op_e          op_e;
   logic [W-1:0]    addend;
   logic [W-1:0]    sum;
   logic            c_half;
   logic            c_sign;
   logic            c_out;

   assign op_e   = fu_op_e'(op);
   assign addend = (op_e == OP_SUB) ? ~b : b;

   fu_ripple_add #(.W(W)) u_add (
      .x      (a),
      .yv     (addend),
      .ci     (cin),
      .sum    (sum),
      .c_half (c_half),
      .c_sign (c_sign),
      .c_out  (c_out)
   );

   always_comb begin
      res = a;
      upd = '0;
      unique case (op_e)
         OP_ADD, OP_SUB: begin
            res      = sum;
            upd.c    = c_out;
            upd.h    = c_half;
            upd.v    = c_out ^ c_sign;
            upd.n    = sum[W-1];
            upd.z    = (sum == '0);
            upd.we_n = 1'b1;
            upd.we_v = 1'b1;
            upd.we_h = 1'b1;
            upd.we_z = 1'b1;
            upd.we_c = 1'b1;
         end
         OP_ASL, OP_ROL: begin
            res      = {a[W-2:0], (op_e == OP_ROL) ? cin : 1'b0};
            upd.c    = a[W-1];
            upd.n    = res[W-1];
            upd.z    = (res == '0);
            upd.we_n = 1'b1;
            upd.we_z = 1'b1;
            upd.we_c = 1'b1;
         end
         OP_LSR, OP_ROR: begin
            res      = {(op_e == OP_ROR) ? cin : 1'b0, a[W-1:1]};
            upd.c    = a[0];
            upd.n    = res[W-1];
            upd.z    = (res == '0);
            upd.we_n = 1'b1;
            upd.we_z = 1'b1;
            upd.we_c = 1'b1;
         end
         OP_MOV: begin
            res      = b;
            upd.n    = b[W-1];
            upd.z    = (b == '0);
            upd.we_n = 1'b1;
            upd.we_z = 1'b1;
         end
         OP_BIT: begin
            upd.n    = b[W-1];
            upd.v    = b[W-2];
            upd.z    = ((a & b) == '0);
            upd.we_n = 1'b1;
            upd.we_v = 1'b1;
            upd.we_z = 1'b1;
         end
         OP_TSTW: begin
            upd.n    = y[W-1];
            upd.z    = ({y, a} == '0);
            upd.we_n = 1'b1;
            upd.we_z = 1'b1;
         end
         default: begin
            res = a;
         end
      endcase
   end
endmodule

// File: rtl/fu_psw_reg.sv
module fu_psw_reg
   import flag_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op,
   input  flag_upd_t        upd,
   output logic [PSW_W-1:0] psw
);
   fu_op_e op_e;
   assign op_e = fu_op_e'(op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psw <= '0;
      end else if (op_valid) begin
         if (upd.we_n) psw[BIT_N] <= upd.n;
         if (upd.we_v) psw[BIT_V] <= upd.v;
         if (upd.we_h) psw[BIT_H] <= upd.h;
         if (upd.we_z) psw[BIT_Z] <= upd.z;
         if (upd.we_c) psw[BIT_C] <= upd.c;
         unique case (op_e)
            OP_SETG: psw[BIT_G] <= 1'b1;
            OP_CLRG: psw[BIT_G] <= 1'b0;
            OP_EI:   psw[BIT_I] <= 1'b1;
            OP_DI:   psw[BIT_I] <= 1'b0;
            OP_CLRV: begin
               psw[BIT_V] <= 1'b0;
               psw[BIT_H] <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fu_dp_page.sv
module fu_dp_page #(
   parameter int W = 8
) (
   input  logic         page_sel,
   input  logic [W-1:0] offset,
   output logic [W:0]   addr
);
   assign addr = {page_sel, offset};
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
   import flag_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [3:0]   op,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic [W-1:0] y_in,
   input  logic         carry_in,
   input  logic [W-1:0] dp_offset,
   output logic [W-1:0] result,
   output logic [7:0]   psw_q,
   output logic [W:0]   dp_addr
);
   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("psw_flag_unit: W must be even and at least 4");
   end

   flag_upd_t upd;

   fu_arith_core #(.W(W)) u_core (
      .op  (op),
      .a   (a_in),
      .b   (b_in),
      .y   (y_in),
      .cin (carry_in),
      .res (result),
      .upd (upd)
   );

   fu_psw_reg u_psw (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op       (op),
      .upd      (upd),
      .psw      (psw_q)
   );

   fu_dp_page #(.W(W)) u_page (
      .page_sel (psw_q[BIT_G]),
      .offset   (dp_offset),
      .addr     (dp_addr)
   );
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
   import flag_pkg::*;
#(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [3:0]   op,
   input logic [W-1:0] b_in,
   input logic [W-1:0] dp_offset,
   input logic [7:0]   psw_q,
   input logic [W:0]   dp_addr
);
   AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> psw_q == 8'h00); // R1

   AST_B_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      psw_q[BIT_B] == 1'b0); // R1

   AST_BIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_BIT) |=> (psw_q[BIT_N] == $past(b_in[W-1]) && psw_q[BIT_V] == $past(b_in[W-2]))); // R6

   AST_SETG_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_SETG) |=> dp_addr[W] == 1'b1); // R8

   AST_CLRG_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CLRG) |=> dp_addr[W] == 1'b0); // R8

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      dp_addr[W-1:0] == dp_offset); // R8

   AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_EI) |=> psw_q[BIT_I]); // R9

   AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_DI) |=> !psw_q[BIT_I]); // R9

   AST_CLRV_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CLRV) |=> (!psw_q[BIT_V] && !psw_q[BIT_H])); // R10

   AST_V_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psw_q[BIT_V]) |-> $past(op_valid && (op == OP_ADD || op == OP_SUB || op == OP_BIT))); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(psw_q)); // R11
endmodule

bind psw_flag_unit flag_unit_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op        (op),
   .b_in      (b_in),
   .dp_offset (dp_offset),
   .psw_q     (psw_q),
   .dp_addr   (dp_addr)
);

// File: tb/psw_flag_unit_test.sv
module psw_flag_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op = 4'd0;
   logic [7:0] a_in = 8'd0;
   logic [7:0] b_in = 8'd0;
   logic [7:0] y_in = 8'd0;
   logic       carry_in = 1'b0;
   logic [7:0] dp_offset = 8'd0;
   logic [7:0] result;
   logic [7:0] psw_q;
   logic [8:0] dp_addr;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   logic [7:0] m = 8'h00;

   always #10 clk = ~clk;

   psw_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
      .a_in(a_in), .b_in(b_in), .y_in(y_in), .carry_in(carry_in),
      .dp_offset(dp_offset), .result(result), .psw_q(psw_q), .dp_addr(dp_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int sgn(input logic [7:0] v);
      return v[7] ? int'(v) - 256 : int'(v);
   endfunction

   // called at a negative edge; returns at the following negative edge
   task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] y, input logic ci, input logic v, input string tag);
      logic [7:0] er;
      logic [7:0] nm;
      int s;
      int r;
      nm = m;
      er = a;
      case (o)
         4'd1: begin
            s = int'(a) + int'(b) + int'(ci);
            er = 8'(s);
            nm[0] = (s > 255);
            nm[3] = ((int'(a) % 16) + (int'(b) % 16) + int'(ci)) > 15;
            r = sgn(a) + sgn(b) + int'(ci);
            nm[6] = (r > 127) || (r < -128);
            nm[7] = er[7];
            nm[1] = (er == 8'd0);
         end
         4'd2: begin
            s = int'(a) - int'(b) - (1 - int'(ci));
            er = 8'(s);
            nm[0] = (s >= 0);
            nm[3] = ((int'(a) % 16) - (int'(b) % 16) - (1 - int'(ci))) >= 0;
            r = sgn(a) - sgn(b) - (1 - int'(ci));
            nm[6] = (r > 127) || (r < -128);
            nm[7] = er[7];
            nm[1] = (er == 8'd0);
         end
         4'd3, 4'd4, 4'd5, 4'd6: begin
            if (o == 4'd3 || o == 4'd5) begin
               er = 8'((int'(a) * 2) % 256) + ((o == 4'd5) ? 8'(ci) : 8'd0);
               nm[0] = a[7];
            end else begin
               er = 8'(int'(a) / 2) + ((o == 4'd6 && ci) ? 8'd128 : 8'd0);
               nm[0] = a[0];
            end
            nm[7] = er[7];
            nm[1] = (er == 8'd0);
         end
         4'd7: begin
            er = b;
            nm[7] = b[7];
            nm[1] = (b == 8'd0);
         end
         4'd8: begin
            nm[7] = b[7];
            nm[6] = b[6];
            nm[1] = ((a & b) == 8'd0);
         end
         4'd9: begin
            nm[7] = y[7];
            nm[1] = (int'(y) * 256 + int'(a)) == 0;
         end
         4'd10: nm[5] = 1'b1;
         4'd11: nm[5] = 1'b0;
         4'd12: nm[2] = 1'b1;
         4'd13: nm[2] = 1'b0;
         4'd14: begin
            nm[6] = 1'b0;
            nm[3] = 1'b0;
         end
         default: ;
      endcase
      if (!v) nm = m;
      op = o; a_in = a; b_in = b; y_in = y; carry_in = ci; op_valid = v;
      dp_offset = b ^ 8'h3C;
      #1;
      chk({tag, " result"}, 32'(result), 32'(er));
      @(posedge clk);
      @(negedge clk);
      chk({tag, " psw"}, 32'(psw_q), 32'(nm));
      chk("R8 dp_addr", 32'(dp_addr), 32'({nm[5], b ^ 8'h3C}));
      m = nm;
   endtask

   initial begin : watchdog
      while (cycles < 190000) begin
         @(posedge clk);
         cycles++;
      end
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      dp_offset = 8'h5A;
      repeat (3) @(negedge clk);
      chk("R1 psw during reset", 32'(psw_q), 32'h00);
      chk("R1 dp_addr during reset", 32'(dp_addr), 32'h05A);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 psw after release", 32'(psw_q), 32'h00);

      // R11: invalid commands and no-op codes leave the status word alone
      run(4'd12, 8'h00, 8'h11, 8'h00, 1'b0, 1'b0, "R11 invalid EI");
      run(4'd14, 8'h00, 8'h22, 8'h00, 1'b0, 1'b0, "R11 invalid CLRV");
      run(4'd0,  8'h00, 8'h33, 8'h00, 1'b1, 1'b1, "R11 op0");
      run(4'd15, 8'h80, 8'h44, 8'h00, 1'b1, 1'b1, "R11 op15");

      // R8 page select and R9 interrupt enable
      run(4'd10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R8 SETG");
      run(4'd10, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, "R8 SETG again");
      run(4'd11, 8'h00, 8'h3C, 8'h00, 1'b0, 1'b1, "R8 CLRG");
      run(4'd12, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, "R9 EI");
      run(4'd13, 8'h00, 8'h02, 8'h00, 1'b0, 1'b1, "R9 DI");
      run(4'd12, 8'h00, 8'h03, 8'h00, 1'b0, 1'b1, "R9 EI again");

      // R10: produce V and H, then clear both
      run(4'd1,  8'h7F, 8'h01, 8'h00, 1'b0, 1'b1, "R2 add 7F+01");
      chk("R10 precondition V,H", 32'(psw_q & 8'h48), 32'h48);
      run(4'd14, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R10 CLRV");
      chk("R10 V,H cleared", 32'(psw_q & 8'h48), 32'h00);

      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 11)
            for (int c = 0; c < 2; c++)
               run(4'd1, 8'(a), 8'(b), 8'h00, c[0], 1'b1, "R2 add");
      run(4'd1, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b1, "R2 add FF+FF+1");
      run(4'd1, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1, "R2 add 80+80");

      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 11)
            for (int c = 0; c < 2; c++)
               run(4'd2, 8'(a), 8'(b), 8'h00, c[0], 1'b1, "R3 sub");
      run(4'd2, 8'h80, 8'h01, 8'h00, 1'b1, 1'b1, "R3 sub 80-01");
      run(4'd2, 8'h10, 8'h01, 8'h00, 1'b1, 1'b1, "R3 sub 10-01");
      run(4'd2, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, "R3 sub 00-FF-1");

      for (int o = 3; o <= 6; o++)
         for (int a = 0; a < 256; a++)
            for (int c = 0; c < 2; c++)
               run(4'(o), 8'(a), 8'(a * 7), 8'h00, c[0], 1'b1, "R4 shift/rotate");

      for (int b = 0; b < 256; b++)
         run(4'd7, 8'(b ^ 8'hA5), 8'(b), 8'h00, 1'b1, 1'b1, "R5 transfer");

      for (int a = 0; a < 256; a += 3)
         for (int b = 0; b < 256; b += 5)
            run(4'd8, 8'(a), 8'(b), 8'h00, 1'b0, 1'b1, "R6 bit test");

      for (int y = 0; y < 256; y += 15)
         for (int a = 0; a < 256; a += 17)
            run(4'd9, 8'(a), 8'h5A, 8'(y), 1'b0, 1'b1, "R7 pair test");
      run(4'd9, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R7 pair zero");
      run(4'd9, 8'h00, 8'h00, 8'h01, 1'b0, 1'b1, "R7 pair high only");
      run(4'd9, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1, "R7 pair low only");
      run(4'd9, 8'h00, 8'h00, 8'h80, 1'b0, 1'b1, "R7 pair sign");

      run(4'd10, 8'h00, 8'hC3, 8'h00, 1'b0, 1'b1, "R8 SETG late");
      run(4'd1,  8'h01, 8'h01, 8'h00, 1'b0, 1'b1, "R8 add keeps G");
      run(4'd13, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R9 DI late");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule